// File: doc/BRIEF.md
# Pointer Load/Store Address Unit

This unit forms data-memory addresses for a small 8-bit core that keeps three 16-bit pointers, named X, Y and Z, in its register file. Each access arrives as an already decoded request. The request carries a pointer select, an addressing mode, a store flag, an unsigned 6-bit offset and a 16-bit absolute address. The unit reads the selected pointer value from the register file inputs and latches everything it needs when it accepts the request. It then drives the memory address and strobes for a fixed number of cycles. On the last cycle it returns an updated pointer value to the register file.

The unit also owns the stack pointer, so it serves push and pop. It serves the program-memory byte read as well: the byte addressed by Z is loaded into register 0. A request is accepted only while the unit is idle. A request presented during an access is held off until the access ends.

Top module: `lsu_addr_unit`

## Requirements
- R1: Plain mode (mode code 0) on X, Y or Z (pointer codes 0, 1, 2) addresses memory at the pointer value itself, performs a load (store flag 0) or a store (store flag 1), and returns no pointer write-back.
- R2: Post-increment mode (mode code 1) addresses memory at the current pointer value. On the final cycle it writes back pointer + 1 to the selected pointer.
- R3: Pre-decrement mode (mode code 2) addresses memory at pointer − 1. It writes back that same decremented value to the selected pointer.
- R4: Offset mode (mode code 3) on Y or Z addresses memory at pointer plus the zero-extended 6-bit offset (0..63). The pointer is left unchanged, so there is no write-back.
- R5: Offset mode with X selected, or any of mode codes 0..3 with pointer code 3, is illegal. `illegal` pulses for one cycle, in the cycle after the request is presented. No busy, memory strobe or write-back follows.
- R6: Absolute mode (mode code 4) addresses memory at the 16-bit absolute address of the request. The pointer select is ignored.
- R7: Every data access is busy for exactly 2 cycles, starting the cycle after acceptance. This covers modes 0–4 and push/pop. `done` is high in the second cycle. `mem_en` is high throughout, `mem_we` follows the store flag, and the address holds steady.
- R8: Push (mode code 5) writes at the stack pointer and then lowers it by 1. Pop (mode code 6) raises the stack pointer by 1 and reads at the raised value. The stack pointer resets to `SP_INIT`.
- R9: Program read (mode code 7) addresses program memory at Z with `prog_en`, never with `mem_en`. It stays busy for exactly 3 cycles, pulses `r0_we` in the last cycle, and leaves Z unchanged.
- R10: All pointer and stack arithmetic wraps modulo 2^16. For example, 0xFFFF + 1 = 0x0000 and 0x0000 − 1 = 0xFFFF.
- R11: A request presented while busy is not accepted. It is accepted in the first idle cycle, and it uses the pointer value written back by the access before it.
- R12: After reset `busy`, `done`, `mem_en`, `prog_en`, `ptr_wb_en` and `illegal` are low, and `sp` equals `SP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| req_mode | input | 3 | Addressing mode code 0..7 |
| req_store | input | 1 | 1 = store, 0 = load (modes 0–4) |
| req_disp | input | 6 | Unsigned offset for mode 3 |
| req_addr | input | 16 | Absolute address for mode 4 |
| ptr_x | input | 16 | Current X value from the register file |
| ptr_y | input | 16 | Current Y value from the register file |
| ptr_z | input | 16 | Current Z value from the register file |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of an access |
| mem_addr | output | 16 | Data or program memory address |
| mem_en | output | 1 | Data memory access enable |
| mem_we | output | 1 | Data memory write enable |
| prog_en | output | 1 | Program memory read enable |
| r0_we | output | 1 | Load program byte into register 0 |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_sel | output | 2 | Pointer being written back |
| ptr_wb_val | output | 16 | Pointer write-back value |
| sp | output | 16 | Stack pointer |
| illegal | output | 1 | Rejected request pulse |

## Verification
A pointer write-back and the arrival of the next request that reads the same pointer can fall in the same cycle. The bench provokes this by issuing a post-increment or pre-decrement access and then, while that access is still busy, presenting a second request on the same pointer. The held request must not shorten or overlap the first access; the scoreboard sees this as a busy run of exactly the expected length. The address of the second access must reflect the written-back value, including across the 0xFFFF/0x0000 wrap.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LSU_AW = 16;
  typedef logic [LSU_AW-1:0] addr_t;

  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4,
    AM_PUSH    = 3'd5,
    AM_POP     = 3'd6,
    AM_PROG    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    PSEL_X    = 2'd0,
    PSEL_Y    = 2'd1,
    PSEL_Z    = 2'd2,
    PSEL_NONE = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    SPOP_HOLD = 2'd0,
    SPOP_DEC  = 2'd1,
    SPOP_INC  = 2'd2
  } spop_e;

  // modulo-2^16 pointer arithmetic
  function automatic addr_t step_up(input addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic addr_t step_down(input addr_t a);
    return a - addr_t'(1);
  endfunction

  function automatic addr_t add_offset(input addr_t a, input addr_t q);
    return a + q;
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int DISP_W   = 6,
  parameter int DATA_CYC = 2,
  parameter int PROG_CYC = 3,
  parameter int CNT_W    = 2
) (
  input  amode_e              mode,
  input  psel_e               sel,
  input  logic                store,
  input  logic [DISP_W-1:0]   disp,
  input  addr_t               abs_addr,
  input  addr_t               ptr_x,
  input  addr_t               ptr_y,
  input  addr_t               ptr_z,
  input  addr_t               sp,
  output addr_t               g_addr,
  output logic                g_mem,
  output logic                g_we,
  output logic                g_prog,
  output logic                g_wb,
  output psel_e               g_wbsel,
  output addr_t               g_wbval,
  output spop_e               g_spop,
  output logic [CNT_W-1:0]    g_len,
  output logic                g_bad
);
  localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(DATA_CYC);
  localparam logic [CNT_W-1:0] LEN_PROG = CNT_W'(PROG_CYC);
  localparam int PAD_W = LSU_AW - DISP_W;

  addr_t p_cur;
  addr_t q_ext;
  logic  ptr_ok;

  assign q_ext  = {{PAD_W{1'b0}}, disp};
  assign ptr_ok = (sel != PSEL_NONE);

  always_comb begin
    case (sel)
      PSEL_X:  p_cur = ptr_x;
      PSEL_Y:  p_cur = ptr_y;
      PSEL_Z:  p_cur = ptr_z;
      default: p_cur = ptr_x;
    endcase
  end

  always_comb begin
    g_addr  = '0;
    g_mem   = 1'b0;
    g_we    = 1'b0;
    g_prog  = 1'b0;
    g_wb    = 1'b0;
    g_wbsel = sel;
    g_wbval = '0;
    g_spop  = SPOP_HOLD;
    g_len   = LEN_DATA;
    g_bad   = 1'b0;
    case (mode)
      AM_PLAIN: begin
        g_addr = p_cur;
        g_mem  = 1'b1;
        g_we   = store;
        g_bad  = !ptr_ok;
      end
      AM_POSTINC: begin
        g_addr  = p_cur;
        g_mem   = 1'b1;
        g_we    = store;
        g_wb    = 1'b1;
        g_wbval = step_up(p_cur);
        g_bad   = !ptr_ok;
      end
      AM_PREDEC: begin
        g_addr  = step_down(p_cur);
        g_mem   = 1'b1;
        g_we    = store;
        g_wb    = 1'b1;
        g_wbval = step_down(p_cur);
        g_bad   = !ptr_ok;
      end
      AM_DISP: begin
        g_addr = add_offset(p_cur, q_ext);
        g_mem  = 1'b1;
        g_we   = store;
        g_bad  = !ptr_ok || (sel == PSEL_X);
      end
      AM_DIRECT: begin
        g_addr = abs_addr;
        g_mem  = 1'b1;
        g_we   = store;
      end
      AM_PUSH: begin
        g_addr = sp;
        g_mem  = 1'b1;
        g_we   = 1'b1;
        g_spop = SPOP_DEC;
      end
      AM_POP: begin
        g_addr = step_up(sp);
        g_mem  = 1'b1;
        g_spop = SPOP_INC;
      end
      AM_PROG: begin
        g_addr = ptr_z;
        g_prog = 1'b1;
        g_len  = LEN_PROG;
      end
      default: g_bad = 1'b1;
    endcase
    if (g_bad) begin
      g_mem  = 1'b0;
      g_we   = 1'b0;
      g_wb   = 1'b0;
      g_prog = 1'b0;
      g_spop = SPOP_HOLD;
    end
  end
endmodule

// File: rtl/lsu_sp_reg.sv
module lsu_sp_reg
  import lsu_pkg::*;
#(
  parameter addr_t SP_INIT = 16'h0FFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sp_dec,
  input  logic  sp_inc,
  output addr_t sp
);
  addr_t sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= SP_INIT;
    else if (sp_dec) sp_q <= step_down(sp_q);
    else if (sp_inc) sp_q <= step_up(sp_q);
  end

  assign sp = sp_q;

  // R8: the stack pointer only ever moves by one step
  assert_sp_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> (sp_q == $past(sp_q) + addr_t'(1)) || (sp_q == $past(sp_q) - addr_t'(1)));

  // R8: a move happens only on the cycle after an update strobe
  assert_sp_moves_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> $past(sp_dec || sp_inc));
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              n_bad,
  input  addr_t             n_addr,
  input  logic              n_mem,
  input  logic              n_we,
  input  logic              n_prog,
  input  logic              n_wb,
  input  psel_e             n_wbsel,
  input  addr_t             n_wbval,
  input  spop_e             n_spop,
  input  logic [CNT_W-1:0]  n_len,
  output logic              busy,
  output logic              done,
  output addr_t             mem_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic              prog_en,
  output logic              r0_we,
  output logic              wb_en,
  output psel_e             wb_sel,
  output addr_t             wb_val,
  output logic              sp_dec,
  output logic              sp_inc,
  output logic              illegal
);
  logic             busy_q, mem_q, we_q, prog_q, wb_q, bad_q;
  logic [CNT_W-1:0] cnt_q;
  addr_t            addr_q, wbval_q;
  psel_e            wbsel_q;
  spop_e            spop_q;
  logic             start;
  logic             last_cycle;

  assign start      = accept && !n_bad;
  assign last_cycle = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      mem_q   <= 1'b0;
      we_q    <= 1'b0;
      prog_q  <= 1'b0;
      wb_q    <= 1'b0;
      addr_q  <= '0;
      wbval_q <= '0;
      wbsel_q <= PSEL_X;
      spop_q  <= SPOP_HOLD;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= accept && n_bad;
      if (start) begin
        busy_q  <= 1'b1;
        cnt_q   <= n_len - CNT_W'(1);
        mem_q   <= n_mem;
        we_q    <= n_we;
        prog_q  <= n_prog;
        wb_q    <= n_wb;
        addr_q  <= n_addr;
        wbval_q <= n_wbval;
        wbsel_q <= n_wbsel;
        spop_q  <= n_spop;
      end else if (last_cycle) begin
        busy_q <= 1'b0;
        mem_q  <= 1'b0;
        we_q   <= 1'b0;
        prog_q <= 1'b0;
        wb_q   <= 1'b0;
        spop_q <= SPOP_HOLD;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign busy     = busy_q;
  assign done     = last_cycle;
  assign mem_addr = addr_q;
  assign mem_en   = busy_q && mem_q;
  assign mem_we   = busy_q && we_q;
  assign prog_en  = busy_q && prog_q;
  assign r0_we    = last_cycle && prog_q;
  assign wb_en    = last_cycle && wb_q;
  assign wb_sel   = wbsel_q;
  assign wb_val   = wbval_q;
  assign sp_dec   = last_cycle && (spop_q == SPOP_DEC);
  assign sp_inc   = last_cycle && (spop_q == SPOP_INC);
  assign illegal  = bad_q;

  // R5: a rejected request leaves the unit quiet
  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !busy && !mem_en && !wb_en && !prog_en);

  // R7: address and strobes hold while the access runs
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mem_addr) && $stable(mem_we) && busy);

  // R7: a data access finishes on its second busy cycle
  assert_data_two_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mem_en) |-> $past(busy) && !$past(done));

  // R9: a program read is busy for three cycles and never touches data memory
  assert_prog_three_cycles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prog_en) |-> $past(busy, 2) && $past(busy));
  assert_prog_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> !mem_en && !mem_we);

  // R11: nothing is accepted while busy, so busy cannot restart mid-access
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !$rose(busy) && $stable(wb_sel));
endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
  import lsu_pkg::*;
#(
  parameter int    DISP_W   = 6,
  parameter int    DATA_CYC = 2,
  parameter int    PROG_CYC = 3,
  parameter addr_t SP_INIT  = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_ptr,
  input  logic [2:0]        req_mode,
  input  logic              req_store,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [15:0]       req_addr,
  input  logic [15:0]       ptr_x,
  input  logic [15:0]       ptr_y,
  input  logic [15:0]       ptr_z,
  output logic              busy,
  output logic              done,
  output logic [15:0]       mem_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic              prog_en,
  output logic              r0_we,
  output logic              ptr_wb_en,
  output logic [1:0]        ptr_wb_sel,
  output logic [15:0]       ptr_wb_val,
  output logic [15:0]       sp,
  output logic              illegal
);
  localparam int MAX_CYC = (PROG_CYC > DATA_CYC) ? PROG_CYC : DATA_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  addr_t            g_addr, g_wbval, sp_w;
  logic             g_mem, g_we, g_prog, g_wb, g_bad;
  psel_e            g_wbsel, wbsel_w;
  spop_e            g_spop;
  logic [CNT_W-1:0] g_len;
  logic             accept, sp_dec, sp_inc;

  assign accept = req_valid && !busy;

  lsu_addr_gen #(
    .DISP_W  (DISP_W),
    .DATA_CYC(DATA_CYC),
    .PROG_CYC(PROG_CYC),
    .CNT_W   (CNT_W)
  ) u_gen (
    .mode    (amode_e'(req_mode)),
    .sel     (psel_e'(req_ptr)),
    .store   (req_store),
    .disp    (req_disp),
    .abs_addr(req_addr),
    .ptr_x   (ptr_x),
    .ptr_y   (ptr_y),
    .ptr_z   (ptr_z),
    .sp      (sp_w),
    .g_addr  (g_addr),
    .g_mem   (g_mem),
    .g_we    (g_we),
    .g_prog  (g_prog),
    .g_wb    (g_wb),
    .g_wbsel (g_wbsel),
    .g_wbval (g_wbval),
    .g_spop  (g_spop),
    .g_len   (g_len),
    .g_bad   (g_bad)
  );

  lsu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .n_bad   (g_bad),
    .n_addr  (g_addr),
    .n_mem   (g_mem),
    .n_we    (g_we),
    .n_prog  (g_prog),
    .n_wb    (g_wb),
    .n_wbsel (g_wbsel),
    .n_wbval (g_wbval),
    .n_spop  (g_spop),
    .n_len   (g_len),
    .busy    (busy),
    .done    (done),
    .mem_addr(mem_addr),
    .mem_en  (mem_en),
    .mem_we  (mem_we),
    .prog_en (prog_en),
    .r0_we   (r0_we),
    .wb_en   (ptr_wb_en),
    .wb_sel  (wbsel_w),
    .wb_val  (ptr_wb_val),
    .sp_dec  (sp_dec),
    .sp_inc  (sp_inc),
    .illegal (illegal)
  );

  lsu_sp_reg #(.SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .sp_dec(sp_dec),
    .sp_inc(sp_inc),
    .sp    (sp_w)
  );

  assign ptr_wb_sel = wbsel_w;
  assign sp         = sp_w;

  // R9: program reads never write a pointer back
  assert_prog_keeps_z_R9: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> !ptr_wb_en);

  // R8: stack moves only at the end of a data access
  assert_sp_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_dec || sp_inc) |-> done && mem_en);
endmodule

// File: tb/lsu_addr_unit_tb.sv
module lsu_addr_unit_tb;
  localparam logic [15:0] SP_INIT = 16'h0FFF;

  typedef struct {
    bit          bad;
    logic [15:0] addr;
    bit          mem;
    bit          we;
    bit          prog;
    bit          wb;
    logic [1:0]  wbsel;
    logic [15:0] wbval;
    int          len;
    logic [7:0]  r0;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        r_valid = 1'b0;
  logic [1:0]  r_ptr = 2'd0;
  logic [2:0]  r_mode = 3'd0;
  logic        r_store = 1'b0;
  logic [5:0]  r_disp = 6'd0;
  logic [15:0] r_addr = 16'd0;
  logic [15:0] mx = 16'h0000, my = 16'h0200, mz = 16'hFFFF;
  logic [15:0] msp = SP_INIT;
  logic [7:0]  m_r0 = 8'h00;

  logic        busy, done, mem_en, mem_we, prog_en, r0_we, ptr_wb_en, illegal;
  logic [15:0] mem_addr, ptr_wb_val, sp;
  logic [1:0]  ptr_wb_sel;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int run = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lsu_addr_unit #(.SP_INIT(SP_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(r_valid), .req_ptr(r_ptr),
    .req_mode(r_mode), .req_store(r_store), .req_disp(r_disp), .req_addr(r_addr),
    .ptr_x(mx), .ptr_y(my), .ptr_z(mz),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_en(mem_en),
    .mem_we(mem_we), .prog_en(prog_en), .r0_we(r0_we), .ptr_wb_en(ptr_wb_en),
    .ptr_wb_sel(ptr_wb_sel), .ptr_wb_val(ptr_wb_val), .sp(sp), .illegal(illegal)
  );

  function automatic logic [7:0] pmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // driver: presents a request, waits for idle, records the expectation
  task automatic issue(input logic [1:0] ptr, input logic [2:0] mode, input bit st,
                       input logic [5:0] q, input logic [15:0] k, input string tag);
    exp_t e;
    logic [15:0] p;
    @(negedge clk);
    r_valid = 1'b1; r_ptr = ptr; r_mode = mode; r_store = st; r_disp = q; r_addr = k;
    while (busy) @(negedge clk);
    p = (ptr == 2'd0) ? mx : (ptr == 2'd1) ? my : mz;
    e.bad = (mode <= 3'd3) && ((ptr == 2'd3) || (mode == 3'd3 && ptr == 2'd0));
    e.addr = 16'h0; e.mem = 1; e.we = st; e.prog = 0; e.wb = 0; e.wbsel = ptr;
    e.wbval = 16'h0; e.len = 2; e.r0 = 8'h00; e.tag = tag;
    case (mode)
      3'd0: e.addr = p;
      3'd1: begin e.addr = p; e.wb = 1; e.wbval = p + 16'd1; end
      3'd2: begin e.addr = p - 16'd1; e.wb = 1; e.wbval = p - 16'd1; end
      3'd3: e.addr = p + {10'd0, q};
      3'd4: e.addr = k;
      3'd5: begin e.addr = msp; e.we = 1; msp = msp - 16'd1; end
      3'd6: begin msp = msp + 16'd1; e.addr = msp; e.we = 0; end
      default: begin e.addr = mz; e.mem = 0; e.we = 0; e.prog = 1; e.len = 3; e.r0 = pmem(mz); end
    endcase
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    r_valid = 1'b0;
  endtask

  task automatic settle(input string tag);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(sp == msp, tag, "stack pointer", {16'h0, sp}, {16'h0, msp});
    chk(!busy, tag, "idle after drain", {31'h0, busy}, 32'h0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy) run++;
      if (illegal) begin
        exp_t e;
        if (exp_q.size() == 0) chk(0, "R5", "unexpected illegal", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(e.bad, "R5", {e.tag, " illegal for legal request"}, 1, {31'h0, e.bad});
          chk(!busy && !mem_en && !ptr_wb_en && !prog_en, "R5", {e.tag, " quiet on illegal"},
              {28'h0, busy, mem_en, ptr_wb_en, prog_en}, 0);
        end
      end
      if (done) begin
        exp_t e;
        if (exp_q.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(!e.bad, "R5", {e.tag, " illegal request ran"}, 1, 0);
          chk(mem_addr == e.addr, e.tag, "address", {16'h0, mem_addr}, {16'h0, e.addr});
          chk({mem_en, mem_we, prog_en} == {e.mem, e.we, e.prog}, e.tag, "strobes en/we/prog",
              {29'h0, mem_en, mem_we, prog_en}, {29'h0, e.mem, e.we, e.prog});
          chk(ptr_wb_en == e.wb, e.tag, "write-back enable", {31'h0, ptr_wb_en}, {31'h0, e.wb});
          if (e.wb)
            chk(ptr_wb_sel == e.wbsel && ptr_wb_val == e.wbval, e.tag, "write-back sel/value",
                {14'h0, ptr_wb_sel, ptr_wb_val}, {14'h0, e.wbsel, e.wbval});
          chk(run == e.len, e.prog ? "R9" : "R7", {e.tag, " busy cycles"}, run, e.len);
          chk(r0_we == e.prog, "R9", {e.tag, " r0 strobe"}, {31'h0, r0_we}, {31'h0, e.prog});
          if (r0_we) begin
            m_r0 = pmem(mem_addr);
            chk(m_r0 == e.r0, "R9", "r0 byte", {24'h0, m_r0}, {24'h0, e.r0});
          end
        end
        run = 0;
        if (ptr_wb_en) begin
          case (ptr_wb_sel)
            2'd0: mx = ptr_wb_val;
            2'd1: my = ptr_wb_val;
            default: mz = ptr_wb_val;
          endcase
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !mem_en && !prog_en && !ptr_wb_en && !illegal, "R12", "strobes low",
        {26'h0, busy, done, mem_en, prog_en, ptr_wb_en, illegal}, 0);
    chk(sp == SP_INIT, "R12", "sp reset", {16'h0, sp}, {16'h0, SP_INIT});

    issue(2'd0, 3'd0, 1'b0, 6'd0, 16'h0, "R1");        // plain X load
    issue(2'd1, 3'd0, 1'b1, 6'd0, 16'h0, "R1");        // plain Y store
    issue(2'd0, 3'd1, 1'b1, 6'd0, 16'h0, "R2");        // post-inc X
    issue(2'd0, 3'd0, 1'b0, 6'd0, 16'h0, "R11");       // held, sees X+1
    settle("R2");
    issue(2'd0, 3'd2, 1'b0, 6'd0, 16'h0, "R3");        // pre-dec X -> 0
    issue(2'd0, 3'd2, 1'b1, 6'd0, 16'h0, "R10");       // pre-dec X wraps to FFFF
    issue(2'd0, 3'd0, 1'b0, 6'd0, 16'h0, "R11");       // held, sees FFFF
    issue(2'd1, 3'd2, 1'b0, 6'd0, 16'h0, "R3");        // pre-dec Y
    issue(2'd1, 3'd3, 1'b0, 6'd63, 16'h0, "R4");       // Y + 63
    issue(2'd2, 3'd3, 1'b1, 6'd40, 16'h0, "R10");      // Z FFFF + 40 wraps
    issue(2'd0, 3'd3, 1'b0, 6'd5, 16'h0, "R5");        // X offset illegal
    issue(2'd3, 3'd1, 1'b1, 6'd0, 16'h0, "R5");        // pointer code 3 illegal
    issue(2'd1, 3'd0, 1'b0, 6'd0, 16'h0, "R5");        // after illegal, Y unchanged
    issue(2'd3, 3'd4, 1'b1, 6'd0, 16'hBEEF, "R6");     // absolute, ptr ignored
    issue(2'd0, 3'd4, 1'b0, 6'd0, 16'h0042, "R6");
    settle("R4");
    issue(2'd0, 3'd5, 1'b0, 6'd0, 16'h0, "R8");        // push
    issue(2'd0, 3'd5, 1'b0, 6'd0, 16'h0, "R8");        // push
    settle("R8");
    issue(2'd0, 3'd6, 1'b1, 6'd0, 16'h0, "R8");        // pop
    settle("R8");
    issue(2'd0, 3'd7, 1'b0, 6'd0, 16'h0, "R9");        // program read at FFFF
    issue(2'd2, 3'd1, 1'b0, 6'd0, 16'h0, "R10");       // post-inc Z wraps to 0
    issue(2'd2, 3'd3, 1'b0, 6'd0, 16'h0, "R4");        // Z + 0 = 0
    issue(2'd2, 3'd7, 1'b0, 6'd0, 16'h0, "R9");        // program read at 0
    issue(2'd2, 3'd0, 1'b0, 6'd0, 16'h0, "R9");        // Z unchanged by program read
    settle("R9");
    chk(mx == 16'hFFFF && my == 16'h01FF && mz == 16'h0000, "R10", "final pointers",
        {16'h0, mx}, 32'h0000FFFF);
    finish_run();
  end
endmodule